// File: doc/BRIEF.md
# Parallel EEPROM Page-Load Sequencer

This block sits on the host side of a byte-wide parallel EEPROM. It drives the active-low chip enable, output enable and write enable, the 15-bit address and an 8-bit data bus. The data bus is split into an outgoing byte, a drive enable and an incoming byte, so that a pad ring can join them into one bidirectional bus. A command either loads from 1 to 128 bytes into one page or reads one byte. During a load, bytes arrive on a valid/ready stream and each one becomes one write-enable strobe. The sequencer keeps the time between write-enable falling edges short enough that the device does not start programming before the page is complete.

After the last byte, the sequencer reads the last written location again and again until the device reports that programming has finished. It can detect completion in one of two ways. In the first, bit 7 of the read data matches the bit that was written. In the second, bit 6 stops changing between consecutive reads. It raises a one-cycle `done` when programming finishes, or a one-cycle `timeout_err` if it does not finish in time.

The data stream may stall. If the next byte does not arrive before a safety margin ahead of the device's load window, the sequencer closes the page with the bytes it has, and starts polling.

Top module: `eeprom_page_writer`

## Requirements
- R1: While `ee_we_n` is low, `ee_ce_n` is low and `ee_oe_n` is high. `ee_dq_oe` is high only while `ee_we_n` is low. Each load strobe writes the streamed byte to the device.
- R2: While `ee_oe_n` is low, `ee_ce_n` is low, `ee_we_n` is high and `ee_dq_oe` is low.
- R3: Within one write command, consecutive falling edges of `ee_we_n` are less than `WINDOW_CYC` cycles apart.
- R4: Address bits 14..7 stay at the value of `cmd_addr[14:7]` for the whole write command. Bits 6..0 start at `cmd_addr[6:0]` and increase by one for each byte, wrapping from 127 to 0 inside the same page.
- R5: `cmd_len` is the byte count minus one, so 0 loads one byte and 127 loads 128 bytes.
- R6: With `cmd_mode`=0 (data polling), `done` pulses only after a read of the last written address returns bit 7 equal to bit 7 of the last written byte.
- R7: With `cmd_mode`=1 (toggle watch), `done` pulses only after two consecutive reads return the same bit 6.
- R8: If no byte is accepted within `WINDOW_CYC-MARGIN_CYC` cycles of the previous write-enable fall, no further byte is accepted. The sequencer polls the last written address, and the rest of the page keeps its old contents.
- R9: If completion is not seen within `POLL_TIMEOUT_CYC` cycles of the start of polling, `timeout_err` pulses for one cycle, `done` does not pulse, and the sequencer returns to idle.
- R10: A read command (`cmd_write`=0) performs one read access and returns the byte on `rd_data` with a one-cycle `rd_valid` pulse.
- R11: After reset, all three strobes are high, `ee_dq_oe` is low, `cmd_ready` is high and `wr_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Sequencer idle, command accepted |
| cmd_write | input | 1 | 1 page load, 0 single read |
| cmd_mode | input | 1 | 0 data polling, 1 toggle watch |
| cmd_addr | input | 15 | Start address (write) or read address |
| cmd_len | input | 7 | Bytes to load minus one |
| wr_valid | input | 1 | Stream byte valid |
| wr_ready | output | 1 | Stream byte accepted |
| wr_data | input | 8 | Stream byte |
| rd_valid | output | 1 | Read result pulse |
| rd_data | output | 8 | Read result |
| done | output | 1 | Programming finished pulse |
| timeout_err | output | 1 | Polling timed out pulse |
| ee_ce_n | output | 1 | Device chip enable, active low |
| ee_oe_n | output | 1 | Device output enable, active low |
| ee_we_n | output | 1 | Device write enable, active low |
| ee_addr | output | 15 | Device address |
| ee_dq_out | output | 8 | Data driven to device |
| ee_dq_oe | output | 1 | Data bus drive enable |
| ee_dq_in | input | 8 | Data from device |

## Verification
Some rules are checked by the assertions on every cycle:
- the strobe combinations for loads and reads, and the rule that the data bus is driven only during a write strobe;
- the maximum spacing between write-enable falls;
- the fixed page bits within a command;
- that `done` and `timeout_err` are never raised together.

Other behaviour can only be shown by the bench's device model and scenarios:
- that the correct bytes land at the wrapped offsets;
- that `done` comes no earlier than the end of programming in either detection mode;
- that an early close leaves the rest of the page untouched;
- that a device which never finishes produces a timeout.

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int AW               = 15,
  parameter int OW               = 7,
  parameter int ASET_CYC         = 2,
  parameter int WE_LOW_CYC       = 25,
  parameter int WE_HIGH_CYC      = 13,
  parameter int RD_CYC           = 40,
  parameter int WINDOW_CYC       = 25000,
  parameter int MARGIN_CYC       = 2500,
  parameter int POLL_TIMEOUT_CYC = 2500000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_write,
  input  logic          cmd_mode,
  input  logic [AW-1:0] cmd_addr,
  input  logic [OW-1:0] cmd_len,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [7:0]    wr_data,
  output logic          rd_valid,
  output logic [7:0]    rd_data,
  output logic          done,
  output logic          timeout_err,
  output logic          ee_ce_n,
  output logic          ee_oe_n,
  output logic          ee_we_n,
  output logic [AW-1:0] ee_addr,
  output logic [7:0]    ee_dq_out,
  output logic          ee_dq_oe,
  input  logic [7:0]    ee_dq_in
);
  localparam int LIMIT = WINDOW_CYC - MARGIN_CYC - ASET_CYC - 1;
  localparam int TMAX  = (WINDOW_CYC > POLL_TIMEOUT_CYC) ? WINDOW_CYC : POLL_TIMEOUT_CYC;
  localparam int TW    = $clog2(TMAX + 2);
  localparam int PW    = $clog2(ASET_CYC + WE_LOW_CYC + WE_HIGH_CYC + RD_CYC + 2);
  localparam logic [TW-1:0] LIMIT_T = TW'(LIMIT);
  localparam logic [TW-1:0] TOUT_T  = TW'(POLL_TIMEOUT_CYC - 1);
  localparam logic [TW-1:0] WIN_T   = TW'(WINDOW_CYC - 1);
  localparam logic [PW-1:0] ASET_T  = PW'(ASET_CYC - 1);
  localparam logic [PW-1:0] WLOW_T  = PW'(WE_LOW_CYC - 1);
  localparam logic [PW-1:0] WHIGH_T = PW'(WE_HIGH_CYC - 1);
  localparam logic [PW-1:0] RD_T    = PW'(RD_CYC - 1);

  typedef enum logic [2:0] {S_IDLE, S_LWAIT, S_ASET, S_WLOW, S_WHIGH, S_PREAD, S_PGAP, S_RD} st_t;
  st_t st;

  logic [AW-1:0] addr_q;
  logic [OW-1:0] left_q;
  logic [7:0]    data_q, samp_q;
  logic          mode_q, loaded_q, prev6_q, have_prev_q, wr_op_q;
  logic [PW-1:0] pcnt;
  logic [TW-1:0] tcnt;
  logic          hit;

  assign cmd_ready = (st == S_IDLE);
  assign wr_ready  = (st == S_LWAIT) && (!loaded_q || tcnt < LIMIT_T);
  assign ee_we_n   = !(st == S_WLOW);
  assign ee_dq_oe  = (st == S_WLOW);
  assign ee_oe_n   = !(st == S_PREAD || st == S_RD);
  assign ee_ce_n   = !(st == S_ASET || st == S_WLOW || st == S_PREAD || st == S_RD);
  assign ee_addr   = addr_q;
  assign ee_dq_out = data_q;
  assign hit = mode_q ? (have_prev_q && samp_q[6] == prev6_q) : (samp_q[7] == data_q[7]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      addr_q <= '0;
      left_q <= '0;
      data_q <= '0;
      samp_q <= '0;
      mode_q <= 1'b0;
      loaded_q <= 1'b0;
      prev6_q <= 1'b0;
      have_prev_q <= 1'b0;
      wr_op_q <= 1'b0;
      pcnt <= '0;
      tcnt <= '0;
      rd_valid <= 1'b0;
      rd_data <= '0;
      done <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      done <= 1'b0;
      timeout_err <= 1'b0;
      rd_valid <= 1'b0;
      pcnt <= pcnt + 1'b1;
      if (st != S_IDLE) tcnt <= tcnt + 1'b1;
      case (st)
        S_IDLE: if (cmd_valid) begin
          addr_q <= cmd_addr;
          left_q <= cmd_len;
          mode_q <= cmd_mode;
          wr_op_q <= cmd_write;
          loaded_q <= 1'b0;
          pcnt <= '0;
          st <= cmd_write ? S_LWAIT : S_RD;
        end
        S_LWAIT: if (wr_valid && wr_ready) begin
          data_q <= wr_data;
          if (loaded_q) addr_q[OW-1:0] <= addr_q[OW-1:0] + 1'b1;
          pcnt <= '0;
          st <= S_ASET;
        end else if (loaded_q && tcnt >= LIMIT_T) begin
          tcnt <= '0;
          pcnt <= '0;
          have_prev_q <= 1'b0;
          st <= S_PREAD;
        end
        S_ASET: if (pcnt == ASET_T) begin
          pcnt <= '0;
          tcnt <= '0;
          loaded_q <= 1'b1;
          st <= S_WLOW;
        end
        S_WLOW: if (pcnt == WLOW_T) begin
          pcnt <= '0;
          st <= S_WHIGH;
        end
        S_WHIGH: if (pcnt == WHIGH_T) begin
          pcnt <= '0;
          if (left_q == '0) begin
            tcnt <= '0;
            have_prev_q <= 1'b0;
            st <= S_PREAD;
          end else begin
            left_q <= left_q - 1'b1;
            st <= S_LWAIT;
          end
        end
        S_PREAD: if (pcnt == RD_T) begin
          samp_q <= ee_dq_in;
          st <= S_PGAP;
        end
        S_PGAP: begin
          prev6_q <= samp_q[6];
          have_prev_q <= 1'b1;
          pcnt <= '0;
          if (hit) begin
            done <= 1'b1;
            st <= S_IDLE;
          end else if (tcnt >= TOUT_T) begin
            timeout_err <= 1'b1;
            st <= S_IDLE;
          end else begin
            st <= S_PREAD;
          end
        end
        S_RD: if (pcnt == RD_T) begin
          rd_data <= ee_dq_in;
          rd_valid <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_LOAD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_we_n |-> (!ee_ce_n && ee_oe_n)); // R1
  AST_DRIVE_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ee_dq_oe |-> !ee_we_n); // R1
  AST_READ_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_oe_n |-> (!ee_ce_n && ee_we_n && !ee_dq_oe)); // R2
  AST_LOAD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ee_we_n) && $past(loaded_q) && $past(st) != S_IDLE) |-> ($past(tcnt) < WIN_T)); // R3
  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && $past(st) != S_IDLE && wr_op_q) |-> $stable(ee_addr[AW-1:OW])); // R4
  AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout_err)); // R9
endmodule

// File: tb/test_eeprom_page_writer.sv
`timescale 1ns/1ps
module test_eeprom_page_writer;
  localparam int WIN  = 60;
  localparam int PROG = 150;
  localparam int NEVER = 32'h7fffffff;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic cmd_valid = 0, cmd_write = 0, cmd_mode = 0, wr_valid = 0;
  logic [14:0] cmd_addr = '0;
  logic [6:0] cmd_len = '0;
  logic [7:0] wr_data = '0;
  logic cmd_ready, wr_ready, rd_valid, done, timeout_err;
  logic [7:0] rd_data;
  logic ee_ce_n, ee_oe_n, ee_we_n, ee_dq_oe;
  logic [14:0] ee_addr;
  logic [7:0] ee_dq_out;
  logic [7:0] ee_dq_in;

  eeprom_page_writer #(.ASET_CYC(1), .WE_LOW_CYC(3), .WE_HIGH_CYC(2), .RD_CYC(3),
    .WINDOW_CYC(WIN), .MARGIN_CYC(10), .POLL_TIMEOUT_CYC(400)) i_eeprom_page_writer (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_mode(cmd_mode), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .timeout_err(timeout_err),
    .ee_ce_n(ee_ce_n), .ee_oe_n(ee_oe_n), .ee_we_n(ee_we_n), .ee_addr(ee_addr),
    .ee_dq_out(ee_dq_out), .ee_dq_oe(ee_dq_oe), .ee_dq_in(ee_dq_in));

  // device model
  int cyc = 0;
  logic [7:0] mem [0:1023];
  logic [7:0] last_wr = '0;
  logic [7:0] op_page = '0;
  logic tog = 1'b0, in_op = 1'b0, prev_we = 1'b1, prev_oe = 1'b1;
  logic op_clr = 1'b0, stuck = 1'b0;
  int prog_end = 0, last_fall = 0;
  int viol_gap = 0, viol_page = 0, viol_proto = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    prev_we <= ee_we_n;
    prev_oe <= ee_oe_n;
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] <= 8'hFF;
    end else begin
      if ((!ee_we_n && (ee_ce_n || !ee_oe_n || !ee_dq_oe)) || (ee_dq_oe && ee_we_n) ||
          (!ee_oe_n && (ee_ce_n || !ee_we_n || ee_dq_oe)))
        viol_proto <= viol_proto + 1;
      if (op_clr) in_op <= 1'b0;
      if (!stuck && prog_end == NEVER) prog_end <= 0;
      if (!ee_we_n && prev_we) begin
        if (in_op && !op_clr && cyc - last_fall >= WIN) viol_gap <= viol_gap + 1;
        if (in_op && !op_clr && ee_addr[14:7] != op_page) viol_page <= viol_page + 1;
        in_op <= 1'b1;
        op_page <= ee_addr[14:7];
        last_fall <= cyc;
        prog_end <= stuck ? NEVER : cyc + PROG;
      end
      if (!ee_we_n && ee_dq_oe) begin
        mem[ee_addr[9:0]] <= ee_dq_out;
        last_wr <= ee_dq_out;
      end
      if (!ee_oe_n && prev_oe)
        ee_dq_in <= (cyc < prog_end) ? {~last_wr[7], tog, last_wr[5:0]} : mem[ee_addr[9:0]];
      if (ee_oe_n && !prev_oe) tog <= ~tog;
    end
  end

  typedef struct {int kind; logic [7:0] data; string req;} ev_t;
  ev_t q[$];
  int total = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_ev(input int kind, input logic [7:0] d, input string req);
    ev_t e;
    e.kind = kind; e.data = d; e.req = req;
    q.push_back(e);
  endtask

  task automatic issue(input bit wr, input int addr, input int len, input bit mode);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_write = wr; cmd_addr = 15'(addr); cmd_len = 7'(len); cmd_mode = mode;
    op_clr = 1;
    @(negedge clk);
    cmd_valid = 0; op_clr = 0;
  endtask

  task automatic send(input logic [7:0] d, input int gap);
    repeat (gap) @(negedge clk);
    wr_valid = 1; wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic monitor();
    forever begin
      @(negedge clk);
      if (rst_n && (done || timeout_err || rd_valid)) begin
        int k;
        k = rd_valid ? 2 : (timeout_err ? 1 : 0);
        if (q.size() == 0) begin
          chk(0, "unexpected event", k, -1);
        end else begin
          ev_t e;
          e = q.pop_front();
          chk(k == e.kind, e.req, k, e.kind);
          if (k == 2) chk(rd_data == e.data, e.req, rd_data, e.data);
          if (k == 0) chk(cyc >= prog_end, e.req, cyc, prog_end);
        end
      end
    end
  endtask

  initial begin
    fork
      monitor();
      begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
      end
    join_none

    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(ee_ce_n && ee_oe_n && ee_we_n, "R11 strobes", {ee_ce_n, ee_oe_n, ee_we_n}, 3'b111);
    chk(!ee_dq_oe, "R11 drive", ee_dq_oe, 0);
    chk(cmd_ready, "R11 cmd_ready", cmd_ready, 1);
    chk(!wr_ready, "R11 wr_ready", wr_ready, 0);

    // R6 data polling, R1 bytes land, spaced loads for R3
    expect_ev(0, 0, "R6 data-poll done");
    issue(1, 15'h080, 3, 0);
    send(8'h3C, 0); send(8'h5A, 30); send(8'h0F, 20); send(8'hC3, 35);
    drain();
    chk(mem[10'h080] == 8'h3C, "R1 byte0", mem[10'h080], 8'h3C);
    chk(mem[10'h081] == 8'h5A, "R1 byte1", mem[10'h081], 8'h5A);
    chk(mem[10'h082] == 8'h0F, "R1 byte2", mem[10'h082], 8'h0F);
    chk(mem[10'h083] == 8'hC3, "R1 byte3", mem[10'h083], 8'hC3);
    chk(mem[10'h084] == 8'hFF, "R5 fourth count", mem[10'h084], 8'hFF);

    // R5 full page, R4 wrap, R7 toggle watch
    expect_ev(0, 0, "R7 toggle done");
    issue(1, 15'h105, 127, 1);
    for (int i = 0; i < 128; i++) send(8'(i * 3 + 1), i % 3);
    drain();
    for (int i = 0; i < 128; i++)
      chk(mem[10'h100 | ((5 + i) & 127)] == 8'(i * 3 + 1), "R4 R5 wrapped byte",
          mem[10'h100 | ((5 + i) & 127)], i * 3 + 1);
    chk(mem[10'h180] == 8'hFF, "R4 next page untouched", mem[10'h180], 8'hFF);
    chk(mem[10'h0FF] == 8'hFF, "R4 prior page untouched", mem[10'h0FF], 8'hFF);

    // R8 stall closes page early
    expect_ev(0, 0, "R8 early close done");
    issue(1, 15'h200, 3, 0);
    send(8'h11, 0); send(8'h22, 5);
    drain();
    chk(mem[10'h200] == 8'h11, "R8 first", mem[10'h200], 8'h11);
    chk(mem[10'h201] == 8'h22, "R8 second", mem[10'h201], 8'h22);
    chk(mem[10'h202] == 8'hFF, "R8 third untouched", mem[10'h202], 8'hFF);
    chk(mem[10'h203] == 8'hFF, "R8 fourth untouched", mem[10'h203], 8'hFF);
    chk(!wr_ready && cmd_ready, "R8 stream closed", wr_ready, 0);

    // R9 device never finishes
    stuck = 1;
    expect_ev(1, 0, "R9 timeout");
    issue(1, 15'h280, 0, 0);
    send(8'h5A, 0);
    drain();
    chk(cmd_ready, "R9 back to idle", cmd_ready, 1);
    stuck = 0;
    repeat (3) @(negedge clk);

    // R10 single reads
    expect_ev(2, 8'h0F, "R10 read 082");
    issue(0, 15'h082, 0, 0);
    drain();
    expect_ev(2, 8'h5A, "R10 read 280");
    issue(0, 15'h280, 0, 0);
    drain();

    chk(viol_proto == 0, "R1 R2 strobe rules", viol_proto, 0);
    chk(viol_gap == 0, "R3 load spacing", viol_gap, 0);
    chk(viol_page == 0, "R4 page bits", viol_page, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule